// File: doc/BRIEF.md
# Multi-Mode Phase-Counting Encoder Counter

This block tracks position from encoder-style phase signals. Four raw phase inputs arrive asynchronously. Each input passes through a two-stage synchroniser. A third stage then keeps the previous settled level for edge detection. There are two counting channels. Each channel decodes its own pair of phases under a 4-bit mode code and steps its count up or down, clearing against a programmable ceiling.

A shared configuration register sets how the channels are used:
- They can run as two independent 16-bit counters.
- They can be fused into one 32-bit counter. In that case the low channel's mode and direction logic drive the whole value, with a dedicated 32-bit ceiling.
- The same register chooses whether the second channel (or the fused counter) listens to the A/B pair or the C/D pair.

All registers sit behind a single-cycle write strobe with a combinational read port.

Top module: `phase_count_unit`

## Requirements
- R1: After reset both counts read 0, both 16-bit ceilings read 0xFFFF, the 32-bit ceiling is 0xFFFFFFFF, both mode registers (address 0 low channel, address 1 high channel, 8 bits, code in bits 3:0) read 0x04, the configuration register (address 2) reads 0, and both status registers (address 7 low, address 8 high) read 0x80.
- R2: Mode code 4 (full quadrature) counts one step for each edge of either phase when only one phase changed. With (A,B) passing 00,10,11,01 the count rises; the reverse order makes it fall.
- R3: In quadrature codes 4 and 7, a cycle in which both synchronised phases change together leaves the count and the direction unchanged.
- R4: Mode code 5 (pulse/direction) counts only on a rising A edge, up when B is high and down when B is low. Falling A edges and B edges do not count.
- R5: Mode code 7 (half-resolution on B) counts only on single B edges, with up when A equals B after the edge. A single A edge does not count, but it sets the direction: up when A differs from B.
- R6: Any mode code other than 4, 5 or 7 holds the count.
- R7: Status bit 7 shows the direction of the latest decoded step: 1 for up, 0 for down.
- R8: A count step up from a value equal to the ceiling (low channel ceiling at address 5, high at address 6) gives 0. A step down from 0 gives the ceiling.
- R9: Writing a count register (address 3 low, address 4 high) sets the value read back from the next cycle on.
- R10: Configuration bit 1 routes the high channel to C/D when 1 and to A/B when 0. The low channel always uses A/B outside cascade.
- R11: With configuration bit 0 set, address 3 reads and writes one 32-bit count. The high half is the high channel's count, and a step carries between the halves.
- R12: In cascade, the high channel's mode, ceiling and count-write addresses have no effect on counting. Address 5 then accesses the 32-bit ceiling, which clears the fused count.
- R13: A phase change driven before a rising clock edge changes the count on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 2*CW | Write data |
| rdata_o | output | 2*CW | Read data for addr_i, combinational |
| pha_i | input | 1 | Phase A, asynchronous |
| phb_i | input | 1 | Phase B, asynchronous |
| phc_i | input | 1 | Phase C, asynchronous |
| phd_i | input | 1 | Phase D, asynchronous |

## Verification
The bench builds the block with the default half-width CW of 16, so a count loaded at 0x0000FFFF reaches the carry into the high half in a single step. It programs a ceiling of 3 into the low channel so that both wrap directions show up within a few encoder edges. With the 32-bit ceiling at 0x00010001, the fused counter clears after two steps from the carry point.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam logic [3:0] MODE_X4  = 4'd4;
  localparam logic [3:0] MODE_PD  = 4'd5;
  localparam logic [3:0] MODE_X2B = 4'd7;

  typedef enum logic [3:0] {
    A_MODE_LO = 4'd0,
    A_MODE_HI = 4'd1,
    A_CFG     = 4'd2,
    A_CNT_LO  = 4'd3,
    A_CNT_HI  = 4'd4,
    A_CEIL_LO = 4'd5,
    A_CEIL_HI = 4'd6,
    A_STAT_LO = 4'd7,
    A_STAT_HI = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/pcu_sync.sv
module pcu_sync #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= raw_i[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign cur_o[i]  = s2_q;
    assign prev_o[i] = s3_q;
  end
endmodule

// File: rtl/pcu_decode.sv
module pcu_decode import pcu_pkg::*; (
  input  logic [3:0] mode_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       a_prev_i,
  input  logic       b_prev_i,
  output logic       step_o,
  output logic       dir_set_o,
  output logic       up_o
);
  logic ea, eb;
  assign ea = a_i ^ a_prev_i;
  assign eb = b_i ^ b_prev_i;

  always_comb begin
    step_o    = 1'b0;
    dir_set_o = 1'b0;
    up_o      = 1'b0;
    case (mode_i)
      MODE_X4: begin
        if (ea ^ eb) begin
          step_o    = 1'b1;
          dir_set_o = 1'b1;
          up_o      = ea ? (a_i ^ b_i) : ~(a_i ^ b_i);
        end
      end
      MODE_PD: begin
        if (ea && a_i) begin
          step_o    = 1'b1;
          dir_set_o = 1'b1;
          up_o      = b_i;
        end
      end
      MODE_X2B: begin
        if (eb && !ea) begin
          step_o    = 1'b1;
          dir_set_o = 1'b1;
          up_o      = ~(a_i ^ b_i);
        end else if (ea && !eb) begin
          // A edge only steers direction
          dir_set_o = 1'b1;
          up_o      = a_i ^ b_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/phase_count_unit.sv
module phase_count_unit import pcu_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [3:0]    addr_i,
  input  logic [2*CW-1:0] wdata_i,
  output logic [2*CW-1:0] rdata_o,
  input  logic          pha_i,
  input  logic          phb_i,
  input  logic          phc_i,
  input  logic          phd_i
);
  localparam int WW  = 2 * CW;
  localparam int NCH = 2;
  localparam logic [WW-1:0] ONE_W = WW'(1);
  localparam logic [CW-1:0] ONE_N = CW'(1);

  logic [7:0]    mode_q [NCH];
  logic [CW-1:0] cnt_q  [NCH];
  logic [CW-1:0] ceil_q [NCH];
  logic          dir_q  [NCH];
  logic [WW-1:0] ceil_w_q;
  logic          casc_q, pair_q;

  logic [3:0] ph_cur, ph_prev;
  logic [1:0] sel_cur, sel_prev;
  logic [1:0] dec_cur  [NCH];
  logic [1:0] dec_prev [NCH];
  logic [NCH-1:0] step, dset, up;
  logic wr_lo, wr_hi;

  pcu_sync #(.N(4)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({phd_i, phc_i, phb_i, pha_i}),
    .cur_o  (ph_cur),
    .prev_o (ph_prev)
  );

  assign sel_cur  = pair_q ? ph_cur[3:2]  : ph_cur[1:0];
  assign sel_prev = pair_q ? ph_prev[3:2] : ph_prev[1:0];
  assign dec_cur[0]  = casc_q ? sel_cur  : ph_cur[1:0];
  assign dec_prev[0] = casc_q ? sel_prev : ph_prev[1:0];
  assign dec_cur[1]  = sel_cur;
  assign dec_prev[1] = sel_prev;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    pcu_decode i_dec (
      .mode_i    (mode_q[k][3:0]),
      .a_i       (dec_cur[k][0]),
      .b_i       (dec_cur[k][1]),
      .a_prev_i  (dec_prev[k][0]),
      .b_prev_i  (dec_prev[k][1]),
      .step_o    (step[k]),
      .dir_set_o (dset[k]),
      .up_o      (up[k])
    );
  end

  function automatic logic [WW-1:0] next_w(input logic [WW-1:0] c,
                                           input logic [WW-1:0] lim,
                                           input logic u);
    if (u) return (c == lim) ? '0 : c + ONE_W;
    return (c == '0) ? lim : c - ONE_W;
  endfunction

  function automatic logic [CW-1:0] next_n(input logic [CW-1:0] c,
                                           input logic [CW-1:0] lim,
                                           input logic u);
    if (u) return (c == lim) ? '0 : c + ONE_N;
    return (c == '0) ? lim : c - ONE_N;
  endfunction

  logic [WW-1:0] nxt_w;
  logic [CW-1:0] nxt_n0, nxt_n1;
  assign nxt_w  = next_w({cnt_q[1], cnt_q[0]}, ceil_w_q, up[0]);
  assign nxt_n0 = next_n(cnt_q[0], ceil_q[0], up[0]);
  assign nxt_n1 = next_n(cnt_q[1], ceil_q[1], up[1]);

  assign wr_lo = wr_en_i && (addr_i == A_CNT_LO);
  assign wr_hi = wr_en_i && (addr_i == A_CNT_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NCH; k++) begin
        mode_q[k] <= {4'd0, MODE_X4};
        cnt_q[k]  <= '0;
        ceil_q[k] <= '1;
        dir_q[k]  <= 1'b1;
      end
      ceil_w_q <= '1;
      casc_q   <= 1'b0;
      pair_q   <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (addr_i)
          A_MODE_LO: mode_q[0] <= wdata_i[7:0];
          A_MODE_HI: mode_q[1] <= wdata_i[7:0];
          A_CFG: begin
            casc_q <= wdata_i[0];
            pair_q <= wdata_i[1];
          end
          A_CEIL_LO: begin
            if (casc_q) ceil_w_q <= wdata_i;
            else        ceil_q[0] <= wdata_i[CW-1:0];
          end
          A_CEIL_HI: ceil_q[1] <= wdata_i[CW-1:0];
          default: ;
        endcase
      end
      // low channel / fused counter
      if (wr_lo) begin
        if (casc_q) {cnt_q[1], cnt_q[0]} <= wdata_i;
        else        cnt_q[0] <= wdata_i[CW-1:0];
      end else if (step[0]) begin
        if (casc_q) {cnt_q[1], cnt_q[0]} <= nxt_w;
        else        cnt_q[0] <= nxt_n0;
      end
      // high channel only when independent
      if (!casc_q) begin
        if (wr_hi)        cnt_q[1] <= wdata_i[CW-1:0];
        else if (step[1]) cnt_q[1] <= nxt_n1;
      end
      if (dset[0])            dir_q[0] <= up[0];
      if (!casc_q && dset[1]) dir_q[1] <= up[1];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MODE_LO: rdata_o[7:0] = mode_q[0];
      A_MODE_HI: rdata_o[7:0] = mode_q[1];
      A_CFG:     rdata_o[1:0] = {pair_q, casc_q};
      A_CNT_LO: begin
        if (casc_q) rdata_o = {cnt_q[1], cnt_q[0]};
        else        rdata_o[CW-1:0] = cnt_q[0];
      end
      A_CNT_HI:  rdata_o[CW-1:0] = cnt_q[1];
      A_CEIL_LO: begin
        if (casc_q) rdata_o = ceil_w_q;
        else        rdata_o[CW-1:0] = ceil_q[0];
      end
      A_CEIL_HI: rdata_o[CW-1:0] = ceil_q[1];
      A_STAT_LO: rdata_o[7] = dir_q[0];
      A_STAT_HI: rdata_o[7] = dir_q[1];
      default: ;
    endcase
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker import pcu_pkg::*; #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          casc_i,
  input logic          wr_lo_i,
  input logic [2*CW-1:0] wdata_i,
  input logic [7:0]    mode0_i,
  input logic [CW-1:0] cnt0_i,
  input logic [CW-1:0] cnt1_i,
  input logic [CW-1:0] ceil0_i,
  input logic          step0_i,
  input logic          up0_i,
  input logic          dset0_i,
  input logic          dir0_i,
  input logic          a0_i,
  input logic          b0_i,
  input logic          a0p_i,
  input logic          b0p_i
);
  logic idle_mode;
  assign idle_mode = (mode0_i[3:0] != MODE_X4) && (mode0_i[3:0] != MODE_PD) &&
                     (mode0_i[3:0] != MODE_X2B);

  p_wrap_up_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!casc_i && !wr_lo_i && step0_i && up0_i && cnt0_i == ceil0_i) |=> (cnt0_i == '0));

  p_wrap_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!casc_i && !wr_lo_i && step0_i && !up0_i && cnt0_i == '0) |=> (cnt0_i == $past(ceil0_i)));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!casc_i && !wr_lo_i && idle_mode) |=> $stable(cnt0_i));

  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !casc_i) |=> (cnt0_i == $past(wdata_i[CW-1:0])));

  p_dir_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dset0_i |=> (dir0_i == $past(up0_i)));

  p_double_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode0_i[3:0] == MODE_X4 || mode0_i[3:0] == MODE_X2B) &&
     (a0_i != a0p_i) && (b0_i != b0p_i)) |-> (!step0_i && !dset0_i));

  p_hi_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_i && !wr_lo_i && !step0_i) |=> $stable(cnt1_i));
endmodule

bind phase_count_unit pcu_checker #(.CW(CW)) i_pcu_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .casc_i  (casc_q),
  .wr_lo_i (wr_lo),
  .wdata_i (wdata_i),
  .mode0_i (mode_q[0]),
  .cnt0_i  (cnt_q[0]),
  .cnt1_i  (cnt_q[1]),
  .ceil0_i (ceil_q[0]),
  .step0_i (step[0]),
  .up0_i   (up[0]),
  .dset0_i (dset[0]),
  .dir0_i  (dir_q[0]),
  .a0_i    (dec_cur[0][0]),
  .b0_i    (dec_cur[0][1]),
  .a0p_i   (dec_prev[0][0]),
  .b0p_i   (dec_prev[0][1])
);

// File: tb/test_phase_count_unit.sv
module test_phase_count_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [2*CW-1:0] wdata = '0;
  logic [2*CW-1:0] rdata;
  logic pa = 1'b0, pb = 1'b0, pc = 1'b0, pd = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2*CW-1:0] exp;
    string           tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_count_unit #(.CW(CW)) i_phase_count_unit (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pha_i   (pa),
    .phb_i   (pb),
    .phc_i   (pc),
    .phd_i   (pd)
  );

  // monitor: pops expectations and compares
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (rdata !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [2*CW-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [3:0] a, input logic [2*CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ph(input logic na, input logic nb, input logic nc, input logic nd);
    @(negedge clk);
    pa = na; pb = nb; pc = nc; pd = nd;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd3, 32'h0, "R1 cnt_lo");
    rd(4'd4, 32'h0, "R1 cnt_hi");
    rd(4'd5, 32'h0000_FFFF, "R1 ceil_lo");
    rd(4'd6, 32'h0000_FFFF, "R1 ceil_hi");
    rd(4'd0, 32'h04, "R1 mode_lo");
    rd(4'd2, 32'h0, "R1 cfg");
    rd(4'd7, 32'h80, "R1 stat_lo");
    rd(4'd8, 32'h80, "R1 stat_hi");

    // R13 latency: A rises, count moves on third edge
    @(negedge clk);
    pa = 1'b1;
    rd(4'd3, 32'd0, "R13 edge1");
    rd(4'd3, 32'd0, "R13 edge2");
    rd(4'd3, 32'd1, "R13 edge3");
    repeat (2) @(negedge clk);

    // R2 forward then reverse
    ph(1, 1, 0, 0); rd(4'd3, 32'd2, "R2 fwd b rise");
    ph(0, 1, 0, 0); rd(4'd3, 32'd3, "R2 fwd a fall");
    ph(0, 0, 0, 0); rd(4'd3, 32'd4, "R2 fwd b fall");
    rd(4'd7, 32'h80, "R7 up");
    ph(0, 1, 0, 0); rd(4'd3, 32'd3, "R2 rev b rise");
    rd(4'd7, 32'h00, "R7 down");
    ph(1, 1, 0, 0); rd(4'd3, 32'd2, "R2 rev a rise");

    // R3 both phases together
    ph(0, 0, 0, 0); rd(4'd3, 32'd2, "R3 double edge");
    rd(4'd7, 32'h00, "R3 dir kept");

    // R8 ceiling wrap both ways
    wr(4'd5, 32'd3);
    ph(1, 0, 0, 0); rd(4'd3, 32'd3, "R8 up to ceil");
    ph(1, 1, 0, 0); rd(4'd3, 32'd0, "R8 ceil to zero");
    ph(1, 0, 0, 0); rd(4'd3, 32'd3, "R8 zero to ceil");

    // R9 load
    wr(4'd3, 32'h1234);
    rd(4'd3, 32'h1234, "R9 load");

    // R4 pulse/direction
    wr(4'd0, 32'd5);
    ph(0, 0, 0, 0); rd(4'd3, 32'h1234, "R4 a fall");
    ph(0, 1, 0, 0); rd(4'd3, 32'h1234, "R4 b edge");
    ph(1, 1, 0, 0); rd(4'd3, 32'h1235, "R4 a rise up");
    rd(4'd7, 32'h80, "R4 dir up");
    ph(0, 1, 0, 0);
    ph(0, 0, 0, 0);
    ph(1, 0, 0, 0); rd(4'd3, 32'h1234, "R4 a rise down");
    rd(4'd7, 32'h00, "R4 dir down");

    // R5 half resolution on B
    wr(4'd0, 32'd7);
    ph(1, 1, 0, 0); rd(4'd3, 32'h1235, "R5 b edge up");
    ph(0, 1, 0, 0); rd(4'd3, 32'h1235, "R5 a edge no count");
    rd(4'd7, 32'h80, "R5 a sets up");
    ph(1, 1, 0, 0); rd(4'd7, 32'h00, "R5 a sets down");
    ph(1, 0, 0, 0); rd(4'd3, 32'h1234, "R5 b edge down");

    // R6 other codes
    wr(4'd0, 32'd6);
    ph(0, 0, 0, 0); rd(4'd3, 32'h1234, "R6 code6 a");
    ph(0, 1, 0, 0); rd(4'd3, 32'h1234, "R6 code6 b");
    wr(4'd0, 32'd9);
    ph(1, 1, 0, 0); rd(4'd3, 32'h1234, "R6 code9 a");
    ph(1, 0, 0, 0); rd(4'd3, 32'h1234, "R6 code9 b");

    // R10 pair select for high channel
    wr(4'd4, 32'd0);
    wr(4'd2, 32'd2);
    ph(0, 0, 0, 0); rd(4'd4, 32'd0, "R10 a ignored");
    ph(0, 0, 1, 0); rd(4'd4, 32'd1, "R10 c counts");
    ph(1, 0, 1, 0);

    // R11 cascade with carry
    wr(4'd0, 32'd4);
    wr(4'd2, 32'd1);
    wr(4'd3, 32'h0000_FFFF);
    rd(4'd3, 32'h0000_FFFF, "R11 long load");
    ph(1, 1, 1, 0); rd(4'd3, 32'h0001_0000, "R11 carry");
    rd(4'd4, 32'h0001, "R11 high half");

    // R12 high channel ignored, wide ceiling
    wr(4'd1, 32'd6);
    wr(4'd6, 32'd0);
    wr(4'd4, 32'h55);
    rd(4'd3, 32'h0001_0000, "R12 hi write ignored");
    wr(4'd5, 32'h0001_0001);
    rd(4'd5, 32'h0001_0001, "R12 wide ceil");
    ph(0, 1, 1, 0); rd(4'd3, 32'h0001_0001, "R12 step to ceil");
    ph(0, 0, 1, 0); rd(4'd3, 32'h0, "R12 wide clear");
    wr(4'd2, 32'd0);
    rd(4'd5, 32'd3, "R12 narrow ceil kept");
    rd(4'd6, 32'd0, "R12 hi ceil stored");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule